// File: doc/BRIEF.md
# Token-Gated Shared Translation Buffer

This block is a second-level translation buffer that all warps of a multi-application GPU share. A lookup carries a warp number, an application number and a virtual page. It is answered one cycle later with a hit flag and a physical page. The lookup searches two fully associative stores at once: a main store and a much smaller side store. A lookup hits when the tag, made of the application number and the virtual page, matches a valid entry in either store.

When a page walk finishes, its translation enters through the fill port. A fill is written into the main store only if the requesting warp holds a fill token. Fills from all other warps go to the side store, so warps without a token cannot evict the working set of the warps that hold one.

A warp holds a token when its number is below the current token count. The block counts lookup hits and misses over an epoch, and the epoch ends on an external tick. At the tick the count drops when the miss rate is too high and rises when it is low. Two lookup channels share one lookup slot per cycle, and a token holder wins that slot over a warp without a token.

Top module: `tlbtok_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `token_count` equals NUM_WARPS (8), and every lookup misses.
- R2: A warp holds a token when its warp number is less than `token_count`. A fill from a token holder is written to the main store, which has MAIN_ENTRIES (4) entries.
- R3: A fill from a warp without a token is written only to the side store, which has BYP_ENTRIES (2) entries. A later lookup hits on an entry in either store.
- R4: Each entry is tagged with its application number. A lookup with the same virtual page but a different application number misses.
- R5: A granted lookup produces `rsp_valid`=1 in the following cycle. In that cycle `rsp_hit` and `rsp_ppn` reflect the store contents before the lookup's clock edge, and `rsp_ppn` is 0 on a miss.
- R6: `lk_grant` is one-hot or zero, with bit 0 for channel 0 and bit 1 for channel 1. When both channels are valid, channel 1 is granted only if its warp holds a token and channel 0's warp does not; otherwise channel 0 wins. `rsp_chan` reports which channel was served.
- R7: The main store replaces its least recently used entry. Both a fill and a lookup hit count as a use.
- R8: The side store also replaces its least recently used entry, and a lookup hit counts as a use.
- R9: At an epoch tick where misses×8 > 4×lookups (miss rate above one half), the token count falls by 2 and never goes below 1.
- R10: At an epoch tick where misses×8 < lookups (miss rate below one eighth), the token count rises by 2 and never goes above NUM_WARPS. With no lookups in the epoch, or a miss rate between the two thresholds, the count is unchanged.
- R11: The token count changes only at an epoch tick. The hit and miss counts restart from zero at every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk0_valid | input | 1 | Channel 0 lookup request |
| lk0_warp | input | 3 | Channel 0 warp number |
| lk0_app | input | 1 | Channel 0 application number |
| lk0_vpn | input | 8 | Channel 0 virtual page |
| lk1_valid | input | 1 | Channel 1 lookup request |
| lk1_warp | input | 3 | Channel 1 warp number |
| lk1_app | input | 1 | Channel 1 application number |
| lk1_vpn | input | 8 | Channel 1 virtual page |
| lk_grant | output | 2 | Channel served this cycle (one-hot) |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_chan | output | 1 | Channel the response belongs to |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 8 | Physical page on hit, 0 on miss |
| fill_valid | input | 1 | Walk completion fill |
| fill_warp | input | 3 | Warp that requested the walk |
| fill_app | input | 1 | Application number of the fill |
| fill_vpn | input | 8 | Virtual page of the fill |
| fill_ppn | input | 8 | Physical page of the fill |
| epoch_tick | input | 1 | End of epoch pulse |
| token_count | output | 4 | Current number of fill tokens |

## Verification
The hardest state to reach is a small token count. Only then are fills sent to the side store, and only then can the arbiter see a token holder competing against a non-holder. The stimulus reaches that state through epochs made of single missing lookups. Each of these epochs drops the count by two, and the run continues until the count is clamped at one. Routing to the side store is then observed only through capacity. A side fill must survive later main fills, and it must be evicted in least-recently-used order while entries in the main store stay resident.

// File: rtl/tlbtok_pkg.sv
package tlbtok_pkg;

  // Next token count from one epoch's hit/miss totals; thresholds are ratios
  // hi_num/den and lo_num/den compared by cross-multiplication.
  function automatic int unsigned next_tokens(
    input int unsigned cur,
    input int unsigned hits,
    input int unsigned misses,
    input int unsigned hi_num,
    input int unsigned lo_num,
    input int unsigned den,
    input int unsigned step,
    input int unsigned max_tok
  );
    int unsigned total;
    total = hits + misses;
    if (total == 0) return cur;
    if (misses * den > hi_num * total) return (cur > step) ? cur - step : 1;
    if (misses * den < lo_num * total) return (cur + step > max_tok) ? max_tok : cur + step;
    return cur;
  endfunction

endpackage

// File: rtl/tlbtok_store.sv
module tlbtok_store #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 9,
  parameter int PPN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_touch,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IW-1:0]      age_q [ENTRIES];

  logic [IW-1:0] lk_idx, match_idx, free_idx, old_idx, wr_idx, touch_idx;
  logic          wr_match, have_free, touch_en;

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0; lk_ppn = '0;
    wr_match = 1'b0; match_idx = '0;
    have_free = 1'b0; free_idx = '0; old_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && tag_q[i] == lk_tag) begin
        lk_hit = 1'b1; lk_idx = IW'(i); lk_ppn = ppn_q[i];
      end
      if (vld_q[i] && tag_q[i] == wr_tag) begin
        wr_match = 1'b1; match_idx = IW'(i);
      end
      if (!vld_q[i]) begin
        have_free = 1'b1; free_idx = IW'(i);
      end
      if (age_q[i] == OLDEST) old_idx = IW'(i);
    end
    wr_idx    = wr_match ? match_idx : (have_free ? free_idx : old_idx);
    touch_en  = wr_en | (lk_touch & lk_hit);
    touch_idx = wr_en ? wr_idx : lk_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
        age_q[i] <= IW'(i);
      end
    end else begin
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        tag_q[wr_idx] <= wr_tag;
        ppn_q[wr_idx] <= wr_ppn;
      end
      if (touch_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IW'(i) == touch_idx) age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlbtok_arb.sv
module tlbtok_arb #(
  parameter int WARP_W = 3,
  parameter int TOK_W  = 4
) (
  input  logic              v0,
  input  logic              v1,
  input  logic [WARP_W-1:0] w0,
  input  logic [WARP_W-1:0] w1,
  input  logic [TOK_W-1:0]  tok_cnt,
  output logic              holds0,
  output logic              holds1,
  output logic [1:0]        grant
);
  always_comb begin
    holds0 = TOK_W'(w0) < tok_cnt;
    holds1 = TOK_W'(w1) < tok_cnt;
    if (v0 && v1) grant = (holds1 && !holds0) ? 2'b10 : 2'b01;
    else          grant = {v1 & ~v0, v0};
  end
endmodule

// File: rtl/tlbtok_alloc.sv
module tlbtok_alloc
  import tlbtok_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int TOK_W     = 4,
  parameter int CNT_W     = 16,
  parameter int HI_NUM    = 4,
  parameter int LO_NUM    = 1,
  parameter int RATE_DEN  = 8,
  parameter int STEP      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_fire,
  input  logic             lk_hit,
  input  logic             epoch_tick,
  output logic [TOK_W-1:0] token_cnt
);
  logic [CNT_W-1:0] hit_cnt, miss_cnt;
  logic             hit_ev, miss_ev;

  assign hit_ev  = lk_fire & lk_hit;
  assign miss_ev = lk_fire & ~lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_cnt   <= '0;
      miss_cnt  <= '0;
      token_cnt <= TOK_W'(NUM_WARPS);
    end else if (epoch_tick) begin
      token_cnt <= TOK_W'(next_tokens(32'(token_cnt), 32'(hit_cnt), 32'(miss_cnt),
                                      HI_NUM, LO_NUM, RATE_DEN, STEP, NUM_WARPS));
      hit_cnt   <= CNT_W'(hit_ev);
      miss_cnt  <= CNT_W'(miss_ev);
    end else begin
      if (hit_ev && hit_cnt != '1)   hit_cnt  <= hit_cnt + 1'b1;
      if (miss_ev && miss_cnt != '1) miss_cnt <= miss_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tlbtok_top.sv
module tlbtok_top #(
  parameter int NUM_WARPS    = 8,
  parameter int APP_W        = 1,
  parameter int VPN_W        = 8,
  parameter int PPN_W        = 8,
  parameter int MAIN_ENTRIES = 4,
  parameter int BYP_ENTRIES  = 2,
  parameter int CNT_W        = 16,
  parameter int HI_NUM       = 4,
  parameter int LO_NUM       = 1,
  parameter int RATE_DEN     = 8,
  parameter int STEP         = 2,
  localparam int WARP_W      = $clog2(NUM_WARPS),
  localparam int TOK_W       = $clog2(NUM_WARPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk0_valid,
  input  logic [WARP_W-1:0] lk0_warp,
  input  logic [APP_W-1:0]  lk0_app,
  input  logic [VPN_W-1:0]  lk0_vpn,
  input  logic              lk1_valid,
  input  logic [WARP_W-1:0] lk1_warp,
  input  logic [APP_W-1:0]  lk1_app,
  input  logic [VPN_W-1:0]  lk1_vpn,
  output logic [1:0]        lk_grant,
  output logic              rsp_valid,
  output logic              rsp_chan,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  input  logic              fill_valid,
  input  logic [WARP_W-1:0] fill_warp,
  input  logic [APP_W-1:0]  fill_app,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              epoch_tick,
  output logic [TOK_W-1:0]  token_count
);
  localparam int TAG_W = APP_W + VPN_W;

  // Named internal events, also observed by the bound checker.
  logic             tok0, tok1, lk_fire, lk_hit;
  logic             fill_token, fill_to_main, fill_to_byp;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             main_hit, byp_hit;
  logic [PPN_W-1:0] main_ppn, byp_ppn, lk_ppn;

  tlbtok_arb #(.WARP_W(WARP_W), .TOK_W(TOK_W)) arb_i (
    .v0(lk0_valid), .v1(lk1_valid), .w0(lk0_warp), .w1(lk1_warp),
    .tok_cnt(token_count), .holds0(tok0), .holds1(tok1), .grant(lk_grant)
  );

  assign lk_fire      = |lk_grant;
  assign lk_tag       = lk_grant[1] ? {lk1_app, lk1_vpn} : {lk0_app, lk0_vpn};
  assign wr_tag       = {fill_app, fill_vpn};
  assign fill_token   = TOK_W'(fill_warp) < token_count;
  assign fill_to_main = fill_valid & fill_token;
  assign fill_to_byp  = fill_valid & ~fill_token;
  assign lk_hit       = main_hit | byp_hit;
  assign lk_ppn       = main_hit ? main_ppn : (byp_hit ? byp_ppn : '0);

  tlbtok_store #(.ENTRIES(MAIN_ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) main_i (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_touch(lk_fire),
    .lk_hit(main_hit), .lk_ppn(main_ppn),
    .wr_en(fill_to_main), .wr_tag(wr_tag), .wr_ppn(fill_ppn)
  );

  tlbtok_store #(.ENTRIES(BYP_ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) byp_i (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_touch(lk_fire),
    .lk_hit(byp_hit), .lk_ppn(byp_ppn),
    .wr_en(fill_to_byp), .wr_tag(wr_tag), .wr_ppn(fill_ppn)
  );

  tlbtok_alloc #(
    .NUM_WARPS(NUM_WARPS), .TOK_W(TOK_W), .CNT_W(CNT_W), .HI_NUM(HI_NUM),
    .LO_NUM(LO_NUM), .RATE_DEN(RATE_DEN), .STEP(STEP)
  ) alloc_i (
    .clk(clk), .rst_n(rst_n), .lk_fire(lk_fire), .lk_hit(lk_hit),
    .epoch_tick(epoch_tick), .token_cnt(token_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_chan  <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_chan  <= lk_grant[1];
      rsp_hit   <= lk_fire & lk_hit;
      rsp_ppn   <= lk_fire ? lk_ppn : '0;
    end
  end
endmodule

// File: rtl/tlbtok_chk.sv
module tlbtok_chk #(
  parameter int NUM_WARPS = 8,
  parameter int TOK_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk0_valid,
  input logic             lk1_valid,
  input logic             tok0,
  input logic             tok1,
  input logic [1:0]       lk_grant,
  input logic             lk_fire,
  input logic             rsp_valid,
  input logic             fill_valid,
  input logic             fill_to_main,
  input logic             fill_to_byp,
  input logic             epoch_tick,
  input logic [TOK_W-1:0] token_count
);
  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> rsp_valid);
  assert_rsp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !rsp_valid);
  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_grant));
  assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_grant[0] |-> lk0_valid) and (lk_grant[1] |-> lk1_valid));
  assert_token_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk0_valid && lk1_valid && tok1 && !tok0) |-> lk_grant == 2'b10);
  assert_fill_one_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $countones({fill_to_main, fill_to_byp}) == 1);
  assert_fill_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |-> !(fill_to_main || fill_to_byp));
  assert_token_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    token_count >= TOK_W'(1) && token_count <= TOK_W'(NUM_WARPS));
  assert_token_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_tick |=> $stable(token_count));
endmodule

bind tlbtok_top tlbtok_chk #(.NUM_WARPS(NUM_WARPS), .TOK_W(TOK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk0_valid(lk0_valid), .lk1_valid(lk1_valid),
  .tok0(tok0), .tok1(tok1), .lk_grant(lk_grant), .lk_fire(lk_fire),
  .rsp_valid(rsp_valid), .fill_valid(fill_valid), .fill_to_main(fill_to_main),
  .fill_to_byp(fill_to_byp), .epoch_tick(epoch_tick), .token_count(token_count)
);

// File: tb/tlbtok_top_tb_top.sv
module tlbtok_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk0_valid = 1'b0, lk1_valid = 1'b0;
  logic [2:0] lk0_warp = '0, lk1_warp = '0;
  logic       lk0_app = 1'b0, lk1_app = 1'b0;
  logic [7:0] lk0_vpn = '0, lk1_vpn = '0;
  logic [1:0] lk_grant;
  logic       rsp_valid, rsp_chan, rsp_hit;
  logic [7:0] rsp_ppn;
  logic       fill_valid = 1'b0;
  logic [2:0] fill_warp = '0;
  logic       fill_app = 1'b0;
  logic [7:0] fill_vpn = '0, fill_ppn = '0;
  logic       epoch_tick = 1'b0;
  logic [3:0] token_count;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tlbtok_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk0_valid(lk0_valid), .lk0_warp(lk0_warp), .lk0_app(lk0_app), .lk0_vpn(lk0_vpn),
    .lk1_valid(lk1_valid), .lk1_warp(lk1_warp), .lk1_app(lk1_app), .lk1_vpn(lk1_vpn),
    .lk_grant(lk_grant), .rsp_valid(rsp_valid), .rsp_chan(rsp_chan),
    .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_app(fill_app),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .epoch_tick(epoch_tick), .token_count(token_count)
  );

  // Vector: kind[26:25] (0 fill, 1 lookup, 2 tick), warp[24:22], app[21],
  // vpn[20:13], ppn or expected ppn[12:5], expected hit[4], expected tokens[3:0].
  localparam int NV = 44;
  localparam logic [26:0] VEC [NV] = '{
    {2'd1, 3'd0, 1'b0, 8'h10, 8'h00, 1'b0, 4'd8},  // R1 empty
    {2'd0, 3'd0, 1'b0, 8'h10, 8'hA1, 1'b0, 4'd8},  // R2 main fill
    {2'd1, 3'd0, 1'b0, 8'h10, 8'hA1, 1'b1, 4'd8},  // R5
    {2'd1, 3'd3, 1'b1, 8'h10, 8'h00, 1'b0, 4'd8},  // R4 other app
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd6},  // R9 2/3 miss
    {2'd0, 3'd7, 1'b0, 8'h20, 8'hB2, 1'b0, 4'd6},  // R3 side
    {2'd0, 3'd6, 1'b0, 8'h21, 8'hB3, 1'b0, 4'd6},  // R3 side
    {2'd1, 3'd1, 1'b0, 8'h20, 8'hB2, 1'b1, 4'd6},  // R8 use
    {2'd0, 3'd7, 1'b0, 8'h22, 8'hB4, 1'b0, 4'd6},  // R8 evict 21
    {2'd1, 3'd0, 1'b0, 8'h21, 8'h00, 1'b0, 4'd6},  // R8
    {2'd1, 3'd0, 1'b0, 8'h20, 8'hB2, 1'b1, 4'd6},  // R8
    {2'd1, 3'd0, 1'b0, 8'h22, 8'hB4, 1'b1, 4'd6},  // R3
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd6},  // R10 middle rate, R11
    {2'd0, 3'd1, 1'b0, 8'h30, 8'hC0, 1'b0, 4'd6},  // R7
    {2'd0, 3'd2, 1'b0, 8'h31, 8'hC1, 1'b0, 4'd6},
    {2'd0, 3'd3, 1'b0, 8'h32, 8'hC2, 1'b0, 4'd6},
    {2'd1, 3'd0, 1'b0, 8'h10, 8'hA1, 1'b1, 4'd6},  // R7 use 10
    {2'd0, 3'd0, 1'b0, 8'h33, 8'hC3, 1'b0, 4'd6},  // R7 evict 30
    {2'd1, 3'd0, 1'b0, 8'h30, 8'h00, 1'b0, 4'd6},  // R7
    {2'd1, 3'd0, 1'b0, 8'h10, 8'hA1, 1'b1, 4'd6},
    {2'd1, 3'd0, 1'b0, 8'h31, 8'hC1, 1'b1, 4'd6},
    {2'd1, 3'd0, 1'b0, 8'h33, 8'hC3, 1'b1, 4'd6},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd6},  // R10 middle
    {2'd1, 3'd0, 1'b0, 8'h32, 8'hC2, 1'b1, 4'd6},
    {2'd1, 3'd0, 1'b0, 8'h10, 8'hA1, 1'b1, 4'd6},
    {2'd1, 3'd0, 1'b0, 8'h31, 8'hC1, 1'b1, 4'd6},
    {2'd1, 3'd0, 1'b0, 8'h33, 8'hC3, 1'b1, 4'd6},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd8},  // R10 rise
    {2'd1, 3'd0, 1'b1, 8'h77, 8'h00, 1'b0, 4'd8},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd6},  // R9
    {2'd1, 3'd0, 1'b1, 8'h77, 8'h00, 1'b0, 4'd6},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd4},
    {2'd1, 3'd0, 1'b1, 8'h77, 8'h00, 1'b0, 4'd4},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd2},
    {2'd1, 3'd0, 1'b1, 8'h77, 8'h00, 1'b0, 4'd2},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // R9 clamp
    {2'd1, 3'd0, 1'b1, 8'h77, 8'h00, 1'b0, 4'd1},
    {2'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // R9 floor
    {2'd0, 3'd1, 1'b1, 8'h40, 8'hD0, 1'b0, 4'd1},  // R2/R3 warp1 no token
    {2'd1, 3'd1, 1'b1, 8'h40, 8'hD0, 1'b1, 4'd1},
    {2'd1, 3'd0, 1'b0, 8'h20, 8'h00, 1'b0, 4'd1},  // R8 20 evicted
    {2'd0, 3'd0, 1'b1, 8'h41, 8'hD1, 1'b0, 4'd1},  // R2 warp0 token
    {2'd1, 3'd0, 1'b1, 8'h41, 8'hD1, 1'b1, 4'd1},
    {2'd1, 3'd1, 1'b1, 8'h40, 8'hD0, 1'b1, 4'd1}   // R3 survives main fill
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk0_valid = 1'b0; lk1_valid = 1'b0; fill_valid = 1'b0; epoch_tick = 1'b0;
  endtask

  // Drive at a falling edge, sample the registered result at the next one.
  task automatic lookup0(input logic [2:0] w, input logic a, input logic [7:0] v,
                         input bit exp_hit, input logic [7:0] exp_ppn, input string req);
    lk0_valid = 1'b1; lk0_warp = w; lk0_app = a; lk0_vpn = v;
    @(negedge clk);
    idle_inputs();
    check(rsp_valid === 1'b1, req, int'(rsp_valid), 1);
    check(rsp_hit === exp_hit, req, int'(rsp_hit), int'(exp_hit));
    check(rsp_ppn === (exp_hit ? exp_ppn : 8'h00), req, int'(rsp_ppn),
          int'(exp_hit ? exp_ppn : 8'h00));
  endtask

  task automatic fill(input logic [2:0] w, input logic a, input logic [7:0] v,
                      input logic [7:0] p);
    fill_valid = 1'b1; fill_warp = w; fill_app = a; fill_vpn = v; fill_ppn = p;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic tick(input logic [3:0] exp_tok, input string req);
    epoch_tick = 1'b1;
    @(negedge clk);
    idle_inputs();
    check(token_count === exp_tok, req, int'(token_count), int'(exp_tok));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check(rsp_valid === 1'b0, "R1", int'(rsp_valid), 0);
    check(token_count === 4'd8, "R1", int'(token_count), 8);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      case (v[26:25])
        2'd0: fill(v[24:22], v[21], v[20:13], v[12:5]);
        2'd1: lookup0(v[24:22], v[21], v[20:13], v[4], v[12:5], "R2-R8 lookup");
        default: tick(v[3:0], "R9/R10 epoch");
      endcase
      check(token_count === v[3:0], "R11 token", int'(token_count), int'(v[3:0]));
    end

    // R6: tokens are 1, so only warp 0 holds one. Channel 1 has the token.
    lk0_valid = 1'b1; lk0_warp = 3'd5; lk0_app = 1'b1; lk0_vpn = 8'h40;
    lk1_valid = 1'b1; lk1_warp = 3'd0; lk1_app = 1'b1; lk1_vpn = 8'h41;
    #1;
    check(lk_grant === 2'b10, "R6 token wins", int'(lk_grant), 2);
    @(negedge clk);
    check(rsp_chan === 1'b1, "R6 chan", int'(rsp_chan), 1);
    check(rsp_hit === 1'b1 && rsp_ppn === 8'hD1, "R6 data", int'(rsp_ppn), 'hD1);
    lk1_valid = 1'b0;   // channel 0 retries alone
    #1;
    check(lk_grant === 2'b01, "R6 retry", int'(lk_grant), 1);
    @(negedge clk);
    check(rsp_chan === 1'b0 && rsp_ppn === 8'hD0, "R6 retry data", int'(rsp_ppn), 'hD0);
    // R6: neither holds a token -> channel 0
    lk1_valid = 1'b1; lk0_warp = 3'd3; lk1_warp = 3'd4;
    #1;
    check(lk_grant === 2'b01, "R6 tie", int'(lk_grant), 1);
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    check(rsp_valid === 1'b0, "R5 idle", int'(rsp_valid), 0);

    // Second reset: contents and tokens restored
    do_reset();
    check(token_count === 4'd8, "R1 again", int'(token_count), 8);
    tick(4'd8, "R10 empty epoch");
    lookup0(3'd0, 1'b1, 8'h41, 1'b0, 8'h00, "R1 cleared");
    tick(4'd6, "R9");
    fill(3'd0, 1'b0, 8'h10, 8'hA1);
    lookup0(3'd0, 1'b0, 8'h10, 1'b1, 8'hA1, "R2");
    lookup0(3'd0, 1'b0, 8'h10, 1'b1, 8'hA1, "R2");
    tick(4'd8, "R10 rise");
    lookup0(3'd0, 1'b0, 8'h10, 1'b1, 8'hA1, "R10");
    tick(4'd8, "R10 ceiling");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule